// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Flag

This block is one side of a parallel peripheral port. It has an 8-bit input port that the CPU reads through a data register, a control register, and an interrupt flag that is set by a selectable transition on an external event line, such as a periodic frame-sync pulse. The event line is synchronized inside the block before its edge is detected. The flag then drives an active-low interrupt request when the enable bit in the control register allows it.

The flag is set on every active edge, whatever the CPU's own interrupt masking is doing. Software that runs with interrupts masked can still poll the flag in the control register. Reading the control register shows the flag but does not clear it. Only a read of the data register acknowledges the flag. A flag that stays pending keeps the request asserted, so an edge that arrives during a long service routine is not lost.

Top module: `edge_irq_port`

## Requirements
- R1: `irq_n` is a registered output. In each cycle it equals the inverse of (flag AND enable) as they stood one clock earlier. Enable is control bit 0. With enable at 0, `irq_n` stays 1.
- R2: Control bit 1 selects the active edge of `evt_in`: 0 selects falling and 1 selects rising. `evt_in` passes through two synchronizer flops. A change of `evt_in` applied before clock edge 1 is therefore seen as flag = 1 after clock edge 3.
- R3: A read (`bus_rd` = 1) at the data address (0) clears the flag on that clock edge.
- R4: A read at the control address (1) returns the flag in bit 7 and leaves the flag unchanged.
- R5: The flag sets on every active edge, even while enable is 0. Software can poll it through control bit 7.
- R6: Once set, the flag stays set until a data-address read, with no limit on how long.
- R7: If an active edge and a data-address read fall in the same cycle, the flag ends set.
- R8: A write at the control address stores `bus_wdata[5:0]` into control bits 5..0. Bit 7 cannot be written. Bit 6 always reads 0.
- R9: After reset the flag and all control bits are 0: the control register reads 0x00 and `irq_n` is 1.
- R10: `bus_rdata` is combinational. It shows `port_in` for a data-address read and is 0 when `bus_rd` is 0 or the address is 2 or 3. Writes to addresses 0, 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| evt_in | input | 1 | Asynchronous event line |
| port_in | input | 8 | Input port sampled by data reads |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data appears in the same cycle as the strobe, so the bench compares it before the clock edge that acts on the strobe. A change on `evt_in` shows in the flag after the third clock edge, and `irq_n` follows the flag or enable one edge later. The bench therefore samples `irq_n` at the falling edge after each rising edge. It keeps a cycle-accurate expected state that it advances on every rising edge. Directed sequences pin the exact cycle of each effect: the third-edge flag, the one-edge request delay, and the edge that lands together with a clear. Seeded random bus traffic and event toggling are then checked every cycle against the same model.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int CTL_W    = 8;
   localparam int IEN_BIT  = 0;
   localparam int EDGE_BIT = 1;
   localparam int WR_TOP   = 5;
   localparam int ZERO_BIT = 6;
   localparam int FLAG_BIT = 7;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic edge_hit
);
   logic [STAGES-1:0] chain;
   logic              prev_q;
   logic              sync_lvl;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign sync_lvl = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_lvl;

   assign edge_hit = rise_sel ? (sync_lvl & ~prev_q) : (~sync_lvl & prev_q);
endmodule

// File: rtl/edge_irq_flag.sv
module edge_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_hit,
   input  logic clr_req,
   input  logic ien,
   output logic flag_q,
   output logic irq_n
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_hit) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= flag_q & ien;

   assign irq_n = ~req_q;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int DATA_ADDR = 0,
   parameter int CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] port_in,
   input  logic              flag_q,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ien,
   output logic              rise_sel,
   output logic              clr_req
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   logic [WR_TOP:0] ctl_q;
   logic [CTL_W-1:0] ctl_view;
   logic             hit_data;
   logic             hit_ctrl;

   assign hit_data = (bus_addr == A_DATA);
   assign hit_ctrl = (bus_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  ctl_q <= '0;
      else if (bus_wr && hit_ctrl) ctl_q <= bus_wdata[WR_TOP:0];

   always_comb begin
      ctl_view                = '0;
      ctl_view[WR_TOP:0]      = ctl_q;
      ctl_view[ZERO_BIT]      = 1'b0;
      ctl_view[FLAG_BIT]      = flag_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && hit_data)      bus_rdata = port_in;
      else if (bus_rd && hit_ctrl) bus_rdata = DATA_W'(ctl_view);
   end

   assign ien      = ctl_q[IEN_BIT];
   assign rise_sel = ctl_q[EDGE_BIT];
   assign clr_req  = bus_rd && hit_data;
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int DATA_ADDR   = 0,
   parameter int CTRL_ADDR   = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_in,
   input  logic [DATA_W-1:0] port_in,
   output logic              irq_n
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must hold the 8-bit control register");
      end
      if (DATA_ADDR == CTRL_ADDR || DATA_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("register addresses must be distinct and fit ADDR_W");
      end
   endgenerate

   logic edge_hit;
   logic clr_req;
   logic ctl_ien;
   logic ctl_rise;
   logic flag_q;

   edge_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(evt_in),
      .rise_sel(ctl_rise), .edge_hit(edge_hit)
   );

   edge_irq_flag i_flag (
      .clk(clk), .rst_n(rst_n), .set_hit(edge_hit), .clr_req(clr_req),
      .ien(ctl_ien), .flag_q(flag_q), .irq_n(irq_n)
   );

   edge_irq_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .port_in(port_in),
      .flag_q(flag_q), .bus_rdata(bus_rdata), .ien(ctl_ien),
      .rise_sel(ctl_rise), .clr_req(clr_req)
   );
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              edge_hit,
   input logic              clr_req,
   input logic              ien,
   input logic              flag_q,
   input logic              irq_n
);
   logic rd_ctrl;
   assign rd_ctrl = bus_rd && (bus_addr == ADDR_W'(CTRL_ADDR));

   AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |=> irq_n); // R1
   AST_IRQ_ON_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && ien) |=> !irq_n); // R1
   AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q); // R5
   AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !edge_hit) |=> !flag_q); // R3
   AST_CTRL_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !edge_hit) |=> $stable(flag_q)); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_req) |=> flag_q); // R6
   AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl |-> (bus_rdata[6] == 1'b0)); // R8
   AST_FLAG_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl |-> (bus_rdata[7] == flag_q)); // R4
endmodule

bind edge_irq_port edge_irq_port_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .edge_hit(edge_hit), .clr_req(clr_req),
   .ien(ctl_ien), .flag_q(flag_q), .irq_n(irq_n)
);

// File: tb/test_edge_irq_port.sv
`timescale 1ns/1ps
module test_edge_irq_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       evt_in = 1'b0;
   logic [7:0] port_in = '0;
   logic       irq_n;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // expected state
   logic m_s1, m_s2, m_prev, m_flag, m_req;
   logic [5:0] m_ctl;

   always #5 clk = ~clk;

   edge_irq_port i_edge_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .port_in(port_in), .irq_n(irq_n)
   );

   function automatic logic [7:0] exp_rdata(input logic [1:0] a, input logic rd,
                                             input logic [7:0] pin);
      if (!rd)          return 8'h00;
      if (a == 2'd0)    return pin;
      if (a == 2'd1)    return {m_flag, 1'b0, m_ctl};
      return 8'h00;
   endfunction

   function automatic logic exp_hit();
      return m_ctl[1] ? (m_s2 & ~m_prev) : (~m_s2 & m_prev);
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_req = 0; m_ctl = '0;
   endtask

   // one bus cycle: drive at falling edge, check read data, clock, check request
   task automatic step(input logic [1:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic ev, input string tag);
      logic hit;
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt_in = ev;
      port_in = 8'($urandom);
      #1;
      check8({tag, " rdata R10"}, bus_rdata, exp_rdata(a, rd, port_in));
      @(posedge clk);
      hit    = exp_hit();
      m_req  = m_flag & m_ctl[0];
      m_flag = hit ? 1'b1 : ((rd && a == 2'd0) ? 1'b0 : m_flag);
      if (wr && a == 2'd1) m_ctl = wd[5:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ev;
      @(negedge clk);
      check8({tag, " irq_n R1"}, {7'd0, irq_n}, {7'd0, ~m_req});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(2'd2, 1'b0, 1'b0, 8'h00, evt_in, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, "R9 reset ctrl");
      bus_rd = 1'b1; bus_addr = 2'd1; #1;
      check8("R9 ctrl after reset", bus_rdata, 8'h00);
      check8("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);

      // R2/R5 falling edge with enable off: flag after third clock edge
      idle(4, "prep");
      step(2'd2, 1'b0, 1'b0, 8'h00, 1'b1, "hi");
      idle(4, "hi");
      step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, "R2 edge c1");
      step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, "R2 edge c2");
      step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, "R2 edge c3");
      bus_addr = 2'd1; bus_rd = 1'b1; #1;
      check8("R2 flag after third edge", bus_rdata, 8'h80);
      check8("R5 flag set with enable off, irq_n high", {7'd0, irq_n}, 8'h01);

      // R1 enable: request one edge after enable lands
      step(2'd1, 1'b0, 1'b1, 8'h01, 1'b0, "R1 enable");
      step(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, "R1 wait");
      check8("R1 irq asserted", {7'd0, irq_n}, 8'h00);

      // R4/R6 repeated control reads keep flag
      for (int i = 0; i < 6; i++) step(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, "R4 ctrl read");
      idle(20, "R6 hold");
      check8("R6 still pending", {7'd0, irq_n}, 8'h00);

      // R3 data read clears
      step(2'd0, 1'b1, 1'b0, 8'h00, 1'b0, "R3 data read");
      bus_addr = 2'd1; bus_rd = 1'b1; #1;
      check8("R3 flag cleared", bus_rdata, 8'h01);
      step(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, "R3 irq release");
      check8("R3 irq released", {7'd0, irq_n}, 8'h01);

      // R7 rising edge coinciding with clear
      step(2'd1, 1'b0, 1'b1, 8'h03, 1'b0, "R7 rising sel");
      idle(3, "R7 prep");
      step(2'd2, 1'b0, 1'b0, 8'h00, 1'b1, "R7 edge c1");
      step(2'd2, 1'b0, 1'b0, 8'h00, 1'b1, "R7 edge c2");
      step(2'd0, 1'b1, 1'b0, 8'h00, 1'b1, "R7 clear same cycle");
      bus_addr = 2'd1; bus_rd = 1'b1; #1;
      check8("R7 edge wins over clear", bus_rdata, 8'h83);

      // R8 write of all ones; R10 writes elsewhere ignored
      step(2'd1, 1'b0, 1'b1, 8'hFF, 1'b1, "R8 write ff");
      step(2'd0, 1'b0, 1'b1, 8'h00, 1'b1, "R10 write data");
      step(2'd3, 1'b0, 1'b1, 8'h00, 1'b1, "R10 write unmapped");
      bus_addr = 2'd1; bus_rd = 1'b1; #1;
      check8("R8 ctrl readback", bus_rdata, 8'hBF);
      step(2'd0, 1'b1, 1'b0, 8'h00, 1'b1, "R3 clear");
      step(2'd1, 1'b0, 1'b1, 8'h00, 1'b1, "restore");

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [1:0] a;
         logic rd, wr, ev;
         a  = 2'($urandom);
         rd = ($urandom % 3) == 0;
         wr = ($urandom % 8) == 0;
         ev = (($urandom % 5) == 0) ? ~evt_in : evt_in;
         step(a, rd, wr, 8'($urandom), ev, "rand R2 R3 R4 R5 R6 R7 R8");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule